// File: doc/BRIEF.md
# Keypad Decoder with Four-Phase Handshake

This block watches a 12-key telephone keypad laid out as four row lines and three column lines. When exactly one row and exactly one column are active, it works out which key is down and converts it to the key's 8-bit ASCII character. It then hands that character to a downstream serial sender through a four-phase request/acknowledge exchange.

The exchange runs as follows. `send_o` rises together with a stable `code_o`. The sender raises `ack_i`, and `send_o` then drops. After that the sender lowers `ack_i`. A held key yields one transfer only. The next transfer needs the keypad to be released while the acknowledge is low.

The keypad lines are asynchronous to the block clock, so they pass through a synchronizer before decoding. The acknowledge arrives from logic in the same clock domain and is used directly.

Top module: `keypad_encoder`

## Requirements
- R1: While reset is held and straight after it, `send_o` is 0 and `code_o` is 8'h00.
- R2: Row line bit r (0 = top row) and column line bit c (0 = leftmost column) name the key. The top three rows hold 1-2-3, 4-5-6 and 7-8-9, and the bottom row holds *, 0 and #. The character is the ASCII code: '1'..'9' are 8'h31..8'h39, '*' is 8'h2A, '0' is 8'h30 and '#' is 8'h23.
- R3: A single valid key with `ack_i` low raises `send_o` and loads its character into `code_o` within a few cycles. `code_o` changes only on the cycle that `send_o` rises.
- R4: `send_o` stays high while `ack_i` is low, and it falls on the cycle after `ack_i` is seen high.
- R5: `code_o` holds its value from the rise of `send_o` until the next transfer starts.
- R6: A key held through a complete exchange does not start a second transfer. A new transfer starts only after the keypad has been released with `ack_i` low.
- R7: If two or more rows, or two or more columns, are active together, the press is ignored: `send_o` stays low and `code_o` is unchanged.
- R8: A key pressed while `ack_i` is high neither raises `send_o` nor changes `code_o`.
- R9: Pressing a different key during a transfer leaves `code_o` at the character being transferred.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| row_i | input | 4 | Keypad row lines, active high, bit 0 = top row |
| col_i | input | 3 | Keypad column lines, active high, bit 0 = left column |
| ack_i | input | 1 | Acknowledge from the downstream sender |
| send_o | output | 1 | Request: a character is offered on `code_o` |
| code_o | output | 8 | ASCII character of the last accepted key |

## Verification
The checker covers the handshake on every cycle:
- `send_o` is held against a low acknowledge and drops one cycle after a high one.
- `send_o` never rises while the acknowledge is high.
- `code_o` never moves except on the rise of `send_o`, which also keeps it frozen for the whole transfer.

The bench scenarios cover the rest:
- the full key-to-ASCII mapping,
- the rejection of multi-row and multi-column chords,
- the single transfer per held key,
- the requirement to release the keypad before a new transfer.

// File: rtl/kp_pkg.sv
package kp_pkg;
  localparam int KP_ROWS = 4;
  localparam int KP_COLS = 3;
  localparam int KP_CODE_W = 8;

  typedef enum logic [1:0] {
    HS_IDLE  = 2'd0,
    HS_OFFER = 2'd1,
    HS_DRAIN = 2'd2
  } hs_state_e;

  // ASCII character of the key at row r, column c
  function automatic logic [KP_CODE_W-1:0] key_ascii(input int r, input int c);
    logic [KP_CODE_W-1:0] ch;
    if (r < KP_ROWS - 1) begin
      ch = 8'h31 + KP_CODE_W'(r * KP_COLS + c);
    end else begin
      case (c)
        0:       ch = 8'h2A;
        1:       ch = 8'h30;
        default: ch = 8'h23;
      endcase
    end
    return ch;
  endfunction
endpackage

// File: rtl/kp_sync.sv
module kp_sync #(
  parameter int W      = 7,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] stg_q [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    logic [W-1:0] stg_d;
    if (s == 0) begin : g_first
      assign stg_d = d_i;
    end else begin : g_next
      assign stg_d = stg_q[s-1];
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stg_q[s] <= '0;
      else        stg_q[s] <= stg_d;
    end
  end

  assign q_o = stg_q[STAGES-1];
endmodule

// File: rtl/kp_decode.sv
module kp_decode
  import kp_pkg::*;
(
  input  logic [KP_ROWS-1:0]   rows_i,
  input  logic [KP_COLS-1:0]   cols_i,
  output logic                 any_press_o,
  output logic                 valid_o,
  output logic [KP_CODE_W-1:0] code_o
);
  assign any_press_o = (|rows_i) && (|cols_i);
  assign valid_o     = $onehot(rows_i) && $onehot(cols_i);

  always_comb begin
    code_o = '0;
    for (int r = 0; r < KP_ROWS; r++) begin
      for (int c = 0; c < KP_COLS; c++) begin
        if (rows_i[r] && cols_i[c]) code_o = key_ascii(r, c);
      end
    end
  end
endmodule

// File: rtl/kp_handshake.sv
module kp_handshake
  import kp_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 any_press_i,
  input  logic                 valid_i,
  input  logic [KP_CODE_W-1:0] code_i,
  input  logic                 ack_i,
  output logic                 send_o,
  output logic [KP_CODE_W-1:0] code_o
);
  hs_state_e            state_q, state_d;
  logic                 send_q, send_d;
  logic                 load_en;
  logic [KP_CODE_W-1:0] code_q;

  always_comb begin
    state_d = state_q;
    send_d  = send_q;
    load_en = 1'b0;
    case (state_q)
      HS_IDLE: begin
        if (valid_i && !ack_i) begin
          load_en = 1'b1;
          send_d  = 1'b1;
          state_d = HS_OFFER;
        end
      end
      HS_OFFER: begin
        if (ack_i) state_d = HS_DRAIN;
      end
      HS_DRAIN: begin
        if (!ack_i && !any_press_i) state_d = HS_IDLE;
      end
      default: state_d = HS_IDLE;
    endcase
    if (ack_i) send_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= HS_IDLE;
      send_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      send_q  <= send_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       code_q <= '0;
    else if (load_en) code_q <= code_i;
  end

  assign send_o = send_q;
  assign code_o = code_q;
endmodule

// File: rtl/keypad_encoder.sv
module keypad_encoder
  import kp_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [KP_ROWS-1:0]   row_i,
  input  logic [KP_COLS-1:0]   col_i,
  input  logic                 ack_i,
  output logic                 send_o,
  output logic [KP_CODE_W-1:0] code_o
);
  localparam int LINES = KP_ROWS + KP_COLS;

  logic                 rst_meta_q, rst_sync_q;
  logic [LINES-1:0]     lines_s;
  logic                 any_press, valid;
  logic [KP_CODE_W-1:0] dec_code;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_sync_q <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_q <= rst_meta_q;
    end
  end

  kp_sync #(.W(LINES), .STAGES(SYNC_STAGES)) i_sync (
    .clk   (clk),
    .rst_n (rst_sync_q),
    .d_i   ({row_i, col_i}),
    .q_o   (lines_s)
  );

  kp_decode i_decode (
    .rows_i      (lines_s[LINES-1:KP_COLS]),
    .cols_i      (lines_s[KP_COLS-1:0]),
    .any_press_o (any_press),
    .valid_o     (valid),
    .code_o      (dec_code)
  );

  kp_handshake i_hs (
    .clk         (clk),
    .rst_n       (rst_sync_q),
    .any_press_i (any_press),
    .valid_i     (valid),
    .code_i      (dec_code),
    .ack_i       (ack_i),
    .send_o      (send_o),
    .code_o      (code_o)
  );
endmodule

// File: rtl/kp_encoder_checker.sv
module kp_encoder_checker (
  input logic       clk,
  input logic       rst_n,
  input logic       ack_i,
  input logic       send_o,
  input logic [7:0] code_o
);
  // R4: request held while acknowledge low
  p_send_held_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (send_o && !ack_i) |=> send_o);

  // R4: request withdrawn one cycle after acknowledge
  p_send_drop_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (send_o && ack_i) |=> !send_o);

  // R8: no new request while acknowledge high
  p_no_rise_on_ack_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!send_o && ack_i) |=> !send_o);

  // R5: data frozen during a transfer
  p_code_stable_r5: assert property (@(posedge clk) disable iff (!rst_n)
    send_o |=> $stable(code_o));

  // R3: data moves only with the rise of the request
  p_code_with_send_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(code_o) |-> $rose(send_o));
endmodule

bind keypad_encoder kp_encoder_checker i_chk (
  .clk    (clk),
  .rst_n  (rst_n),
  .ack_i  (ack_i),
  .send_o (send_o),
  .code_o (code_o)
);

// File: tb/test_keypad_encoder.sv
module test_keypad_encoder;
  logic       clk = 1'b0;
  logic       rst_n;
  logic [3:0] row_i;
  logic [2:0] col_i;
  logic       ack_i;
  logic       send_o;
  logic [7:0] code_o;

  int n_run = 0;
  int n_fail = 0;
  int cycles = 0;
  bit done = 0;

  always #4 clk = ~clk;

  keypad_encoder i_keypad_encoder (
    .clk    (clk),
    .rst_n  (rst_n),
    .row_i  (row_i),
    .col_i  (col_i),
    .ack_i  (ack_i),
    .send_o (send_o),
    .code_o (code_o)
  );

  // {rows, cols, expected ASCII}
  typedef logic [14:0] vec_t;
  localparam vec_t VEC [12] = '{
    {4'b0001, 3'b001, 8'h31}, {4'b0001, 3'b010, 8'h32}, {4'b0001, 3'b100, 8'h33},
    {4'b0010, 3'b001, 8'h34}, {4'b0010, 3'b010, 8'h35}, {4'b0010, 3'b100, 8'h36},
    {4'b0100, 3'b001, 8'h37}, {4'b0100, 3'b010, 8'h38}, {4'b0100, 3'b100, 8'h39},
    {4'b1000, 3'b001, 8'h2A}, {4'b1000, 3'b010, 8'h30}, {4'b1000, 3'b100, 8'h23}
  };

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wait_n(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic press(input logic [3:0] r, input logic [2:0] c);
    row_i = r;
    col_i = c;
  endtask

  task automatic finish_up();
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000 && !done) begin
      n_run++;
      n_fail++;
      $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
      finish_up();
    end
  end

  initial begin
    rst_n = 1'b0;
    row_i = '0;
    col_i = '0;
    ack_i = 1'b0;
    wait_n(3);
    chk("R1 send in reset", 8'(send_o), 8'h0);
    chk("R1 code in reset", code_o, 8'h00);
    rst_n = 1'b1;
    wait_n(4);
    chk("R1 send after reset", 8'(send_o), 8'h0);
    chk("R1 code after reset", code_o, 8'h00);

    // table walk: R2, R3, R4, R6
    for (int k = 0; k < 12; k++) begin
      press(VEC[k][14:11], VEC[k][10:8]);
      wait_n(6);
      chk("R3 send raised", 8'(send_o), 8'h1);
      chk("R2 ascii code", code_o, VEC[k][7:0]);
      ack_i = 1'b1;
      wait_n(2);
      chk("R4 send dropped", 8'(send_o), 8'h0);
      ack_i = 1'b0;
      wait_n(6);
      chk("R6 held key no resend", 8'(send_o), 8'h0);
      press('0, '0);
      wait_n(5);
    end

    // R4: send held while ack low for a long time
    press(4'b0010, 3'b010);
    wait_n(20);
    chk("R4 send held", 8'(send_o), 8'h1);
    chk("R3 code 5", code_o, 8'h35);
    // R9: second key during transfer
    press(4'b0100, 3'b100);
    wait_n(6);
    chk("R9 code kept", code_o, 8'h35);
    ack_i = 1'b1;
    wait_n(2);
    chk("R4 drop", 8'(send_o), 8'h0);
    ack_i = 1'b0;
    wait_n(6);
    chk("R5 code kept after ack", code_o, 8'h35);
    chk("R6 no resend while pressed", 8'(send_o), 8'h0);
    press('0, '0);
    wait_n(5);

    // R7: two rows
    press(4'b0011, 3'b001);
    wait_n(8);
    chk("R7 multi row send", 8'(send_o), 8'h0);
    chk("R7 multi row code", code_o, 8'h35);
    // R7: two columns
    press(4'b0001, 3'b011);
    wait_n(8);
    chk("R7 multi col send", 8'(send_o), 8'h0);
    chk("R7 multi col code", code_o, 8'h35);
    press('0, '0);
    wait_n(5);

    // R8: press with ack high
    ack_i = 1'b1;
    press(4'b0100, 3'b001);
    wait_n(8);
    chk("R8 no send on ack", 8'(send_o), 8'h0);
    chk("R8 code unchanged", code_o, 8'h35);
    press('0, '0);
    wait_n(5);
    ack_i = 1'b0;
    wait_n(3);

    // R6: release then new press starts a transfer
    press(4'b1000, 3'b100);
    wait_n(6);
    chk("R6 new transfer after release", 8'(send_o), 8'h1);
    chk("R2 hash code", code_o, 8'h23);
    ack_i = 1'b1;
    wait_n(2);
    ack_i = 1'b0;
    press('0, '0);
    wait_n(5);

    // R1: reset mid-transfer
    press(4'b0001, 3'b001);
    wait_n(6);
    rst_n = 1'b0;
    wait_n(2);
    chk("R1 reset clears send", 8'(send_o), 8'h0);
    chk("R1 reset clears code", code_o, 8'h00);
    press('0, '0);
    rst_n = 1'b1;
    wait_n(5);

    done = 1;
    finish_up();
  end
endmodule